// File: doc/BRIEF.md
# Prioritized Error Address Capture Register

This block records the double-word address at which a flash memory controller reports trouble. It tracks four event classes. Each class has its own slot that keeps the address of the first event in that class. A class becomes active when its event is recorded and stays active until the controller sends a clear pulse for that class. The register view is 32 bits wide and read-only to user software. It shows the slot of the highest-priority active class. When no class is active, it shows the value it last presented.

The classes, from highest to lowest priority, are:
- class 0: uncorrectable ECC error.
- class 1: read-while-write conflict.
- class 2: program/erase failure. This class is active while the operation's pass indication is withdrawn.
- class 3: corrected single-bit ECC error. This class is recorded only when a configuration input allows it.

A class-0 or class-3 event can be flagged as hitting both double words of one page in the same cycle. In that case the stored address bit 3 is forced low.

Event strobes are single-cycle pulses with no back-pressure. The controller must present each strobe for exactly one clock and cannot be stalled, so the block has no ready signal. A class that is already active does not accept the strobe, and the pulse has no further effect.

Top module: `err_addr_capture`

## Requirements
- R1: After reset, `rd_data` reads 0x00000000 and no class is active.
- R2: A strobe on an inactive class records its address and makes the class active. Further strobes on that class leave the recorded address unchanged while the class stays active.
- R3: `rd_data` shows the recorded address of the active class with the lowest index. Class 0 outranks class 1, class 1 outranks class 2, and class 2 outranks class 3.
- R4: The address field occupies `rd_data[22:3]` (LSB-0 numbering; bits 9 to 28 counted MSB-first). Bits 31:23 and 2:0 always read 0.
- R5: On class 0 or class 3, a strobe with the both-double-words flag stores address bit 3 (field bit 0) as 0. On class 1 or class 2, the flag has no effect.
- R6: A clear pulse deactivates its class so that its next strobe is recorded. A clear and a strobe in the same cycle record the new address and leave the class active.
- R7: While `sec_capture_en` is 0, class-3 strobes are ignored.
- R8: While no class is active, `rd_data` keeps the value it last presented.
- R9: A write in user mode (`wr_user`=1) is ignored. A write in supervisor mode while no class is active loads `wr_data[22:3]` as the presented value and drops the other bits.
- R10: Strobes on several classes in the same cycle are each recorded in their own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_vld | input | 4 | One-cycle event strobe per class, bit index = class |
| ev_addr | input | 80 | Double-word address bits 22:3 per class, class c at [20c+19:20c] |
| ev_both_dw | input | 4 | Both double words of the page hit, per class |
| ev_clr | input | 4 | Flag-clear pulse per class |
| sec_capture_en | input | 1 | Allows recording of class 3 |
| wr_en | input | 1 | Register write strobe |
| wr_user | input | 1 | 1 = user mode, 0 = supervisor |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register view |

## Verification
The bench builds the block with its default parameters: four classes and a 20-bit field for address bits 22:3. With only four classes, it can sweep all fifteen non-empty sets of simultaneous events, each with and without the both-double-words flag. It runs this sweep with single-error capture enabled and again with it disabled. For every set, it computes the expected priority winner, checks that later events do not overwrite recorded addresses, and retires the classes one by one down to the held value. Separate checks cover a clear and a strobe in the same cycle, and the two write modes.

// File: rtl/eacap_pkg.sv
package eacap_pkg;
  localparam int unsigned NCLS     = 4;
  localparam int unsigned ADDR_HI  = 22;
  localparam int unsigned ADDR_LO  = 3;
  localparam int unsigned FIELD_W  = ADDR_HI - ADDR_LO + 1;
  localparam int unsigned REG_W    = 32;

  typedef enum logic [1:0] {
    CLS_ECC_DED = 2'd0,
    CLS_RWW     = 2'd1,
    CLS_PGM_ERS = 2'd2,
    CLS_ECC_SEC = 2'd3
  } cls_e;

  // ECC classes honour the dual double-word flag
  function automatic bit cls_is_ecc(input int unsigned c);
    return (c == CLS_ECC_DED) || (c == CLS_ECC_SEC);
  endfunction
endpackage

// File: rtl/eacap_slot.sv
module eacap_slot #(
  parameter int unsigned FIELD_W  = 20,
  parameter bit          FORCE_DW = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               vld,
  input  logic               both,
  input  logic               clr,
  input  logic [FIELD_W-1:0] addr_in,
  output logic               active,
  output logic [FIELD_W-1:0] addr_q
);
  logic               take;
  logic [FIELD_W-1:0] addr_fmt;

  assign take = vld && en && (!active || clr);

  generate
    if (FORCE_DW) begin : g_dw
      assign addr_fmt = {addr_in[FIELD_W-1:1], addr_in[0] & ~both};
    end else begin : g_plain
      assign addr_fmt = addr_in;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      addr_q <= '0;
    end else if (take) begin
      active <= 1'b1;
      addr_q <= addr_fmt;
    end else if (clr) begin
      active <= 1'b0;
    end
  end

  AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    active && !clr |=> $stable(addr_q)); // R2
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    vld && en && (!active || clr) |=> active && (addr_q[FIELD_W-1:1] == $past(addr_in[FIELD_W-1:1]))); // R6
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !(vld && en) |=> !active); // R6

  generate
    if (FORCE_DW) begin : g_dw_chk
      AST_DUAL_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
        vld && en && both && (!active || clr) |=> !addr_q[0]); // R5
    end
  endgenerate
endmodule

// File: rtl/eacap_prio_sel.sv
module eacap_prio_sel #(
  parameter int unsigned NCLS    = 4,
  parameter int unsigned FIELD_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCLS-1:0]         active,
  input  logic [NCLS*FIELD_W-1:0] addr_flat,
  input  logic                    wr_en,
  input  logic                    wr_user,
  input  logic [FIELD_W-1:0]      wr_field,
  output logic [FIELD_W-1:0]      field_out
);
  logic [FIELD_W-1:0] sel_addr;
  logic [FIELD_W-1:0] hold_q;
  logic               any_act;

  assign any_act = |active;

  // lowest index wins: scan downwards so the last hit is the winner
  always_comb begin
    sel_addr = '0;
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (active[i]) sel_addr = addr_flat[i*FIELD_W +: FIELD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (any_act) begin
      hold_q <= sel_addr;
    end else if (wr_en && !wr_user) begin
      hold_q <= wr_field;
    end
  end

  assign field_out = any_act ? sel_addr : hold_q;

  AST_USER_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !any_act && wr_en && wr_user |=> $stable(hold_q)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !any_act && !wr_en |=> $stable(hold_q)); // R8
endmodule

// File: rtl/err_addr_capture.sv
module err_addr_capture
  import eacap_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCLS-1:0]         ev_vld,
  input  logic [NCLS*FIELD_W-1:0] ev_addr,
  input  logic [NCLS-1:0]         ev_both_dw,
  input  logic [NCLS-1:0]         ev_clr,
  input  logic                    sec_capture_en,
  input  logic                    wr_en,
  input  logic                    wr_user,
  input  logic [REG_W-1:0]        wr_data,
  output logic [REG_W-1:0]        rd_data
);
  logic [NCLS-1:0]         act;
  logic [NCLS*FIELD_W-1:0] slot_addr;
  logic [FIELD_W-1:0]      field;
  logic                    unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[REG_W-1:ADDR_HI+1], wr_data[ADDR_LO-1:0]};

  generate
    for (genvar c = 0; c < NCLS; c++) begin : g_slot
      logic cls_en;
      if (c == CLS_ECC_SEC) begin : g_sec
        assign cls_en = sec_capture_en;
      end else begin : g_on
        assign cls_en = 1'b1;
      end
      eacap_slot #(
        .FIELD_W (FIELD_W),
        .FORCE_DW(cls_is_ecc(c))
      ) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cls_en),
        .vld    (ev_vld[c]),
        .both   (ev_both_dw[c]),
        .clr    (ev_clr[c]),
        .addr_in(ev_addr[c*FIELD_W +: FIELD_W]),
        .active (act[c]),
        .addr_q (slot_addr[c*FIELD_W +: FIELD_W])
      );
    end
  endgenerate

  eacap_prio_sel #(
    .NCLS   (NCLS),
    .FIELD_W(FIELD_W)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (act),
    .addr_flat(slot_addr),
    .wr_en    (wr_en),
    .wr_user  (wr_user),
    .wr_field (wr_data[ADDR_HI:ADDR_LO]),
    .field_out(field)
  );

  assign rd_data = {{(REG_W-ADDR_HI-1){1'b0}}, field, {ADDR_LO{1'b0}}};

  AST_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    act[0] |-> rd_data[ADDR_HI:ADDR_LO] == slot_addr[FIELD_W-1:0]); // R3
  AST_SEC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_capture_en && !act[CLS_ECC_SEC] |=> !act[CLS_ECC_SEC]); // R7
  AST_MULTI_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vld[0] && ev_vld[1] && !act[0] && !act[1] |=> act[0] && act[1]); // R10
endmodule

// File: tb/sim_err_addr_capture.sv
`timescale 1ns/1ps
module sim_err_addr_capture;
  localparam int NC = 4;
  localparam int FW = 20;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NC-1:0]  ev_vld = '0;
  logic [NC*FW-1:0] ev_addr = '0;
  logic [NC-1:0]  ev_both_dw = '0;
  logic [NC-1:0]  ev_clr = '0;
  logic           sec_capture_en = 1'b1;
  logic           wr_en = 1'b0;
  logic           wr_user = 1'b1;
  logic [31:0]    wr_data = '0;
  logic [31:0]    rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] last;

  always #10 clk = ~clk; // 50 MHz

  err_addr_capture u0 (.*);

  function automatic logic [FW-1:0] mk(input int t, input int c);
    return FW'((t * 40503 + c * 9973 + 7) & 32'hFFFFF);
  endfunction

  function automatic logic [31:0] view(input logic [FW-1:0] f);
    return {9'b0, f, 3'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, rd_data, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
    ev_vld = '0; ev_clr = '0; ev_both_dw = '0; wr_en = 1'b0;
  endtask

  task automatic fire(input logic [NC-1:0] m, input int t, input logic both);
    for (int c = 0; c < NC; c++) ev_addr[c*FW +: FW] = mk(t, c);
    ev_vld = m;
    ev_both_dw = both ? m : '0;
    step();
  endtask

  task automatic sweep(input bit sec);
    sec_capture_en = sec;
    for (int m = 1; m < 16; m++) begin
      for (int b = 0; b < 2; b++) begin
        int t;
        logic [NC-1:0] em;
        logic [FW-1:0] ex [NC];
        t = m * 2 + b + (sec ? 0 : 50);
        em = sec ? NC'(m) : NC'(m & 7);
        for (int c = 0; c < NC; c++) begin
          ex[c] = mk(t, c);
          if (b == 1 && (c == 0 || c == 3)) ex[c][0] = 1'b0;
        end
        fire(NC'(m), t, b[0]);
        // R3 R5 R10: priority over simultaneous captures
        begin
          logic [31:0] e;
          e = last;
          for (int c = NC - 1; c >= 0; c--) if (em[c]) e = view(ex[c]);
          check(em == 0 ? "R7" : "R3", e);
          fire(NC'(m), t + 1000, 1'b0);
          check("R2", e); // later strobes do not overwrite
        end
        // retire classes in priority order; R6 R8 R10
        for (int k = 0; k < NC; k++) begin
          logic [31:0] e;
          if (em[k]) last = view(ex[k]);
          ev_clr = NC'(1) << k;
          step();
          e = last;
          for (int c = NC - 1; c > k; c--) if (em[c]) e = view(ex[c]);
          check("R10", e);
        end
        check("R8", last);
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    last = '0;
    repeat (3) @(negedge clk);
    check("R1", 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'h0);

    // R5: both-flag on class 1 has no effect
    for (int c = 0; c < NC; c++) ev_addr[c*FW +: FW] = 20'hFFFFF;
    ev_vld = 4'b0010; ev_both_dw = 4'b0010;
    step();
    check("R5", 32'h007FFFF8);
    // R4: field placement, reserved bits zero
    check("R4", {9'b0, 20'hFFFFF, 3'b0});
    // R6: clear and strobe same cycle records new address
    ev_addr[FW +: FW] = 20'h12345;
    ev_vld = 4'b0010; ev_clr = 4'b0010;
    step();
    check("R6", view(20'h12345));
    ev_clr = 4'b0010;
    step();
    check("R6", view(20'h12345));
    // R6: re-armed, next strobe recorded
    ev_addr[FW +: FW] = 20'h0ABCD;
    ev_vld = 4'b0010;
    step();
    check("R6", view(20'h0ABCD));
    ev_clr = 4'b0010;
    step();
    last = view(20'h0ABCD);

    // R9: user write ignored, supervisor write loads field
    wr_en = 1'b1; wr_user = 1'b1; wr_data = 32'hFFFF_FFFF;
    step();
    check("R9", last);
    wr_en = 1'b1; wr_user = 1'b0; wr_data = 32'hFFFF_FFFF;
    step();
    check("R9", 32'h007FFFF8);
    last = 32'h007FFFF8;
    wr_user = 1'b1;

    sweep(1'b1);
    sweep(1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule